// File: doc/BRIEF.md
# Atomic Bus Lock Controller

This block sits beside a bus arbiter and turns a pair of accesses to one memory bank into a single indivisible sequence. Each bank carries a 2-bit atomic mode. A read-after-write bank is seized by a write, and a write-after-read bank is seized by a read. Once a bank is seized, the bus stays with the master that made the access. Every other master's grant is masked until that master completes the pair with the opposite direction on the same bank.

A hardware watchdog bounds the hold time. If the pair is not completed within `TIMEOUT` bus cycles, the lock is dropped anyway and a sticky interrupt flag is raised. The flag stays set until the interrupt clear input is pulsed. The arbiter's own grant vector passes through the block and is masked on its way out. Internal and external masters are treated the same way, because each one is identified only by its master index.

Top module: `atomic_lock_ctrl`

## Requirements
- R1: A valid write to a bank whose mode field is 2'b01 (read-after-write; bank k's field is bits [2k+1:2k] of `bank_mode_i`) while no lock is held sets `lock_active_o` from the next cycle, and `lock_master_o` shows the accessing master.
- R2: A valid read to a bank whose mode field is 2'b10 (write-after-read) while no lock is held starts a lock in the same way.
- R3: Modes 2'b00 and 2'b11 never start a lock. A read to a 2'b01 bank never starts a lock, and neither does a write to a 2'b10 bank.
- R4: While a lock is held, `gnt_o` equals `gnt_req_i` with every bit cleared except the owner's bit. While no lock is held, `gnt_o` equals `gnt_req_i`. The path is combinational.
- R5: A read-after-write lock is released by a read from the owner to the locked bank. A write-after-read lock is released by a write from the owner to the locked bank. `lock_active_o` is low from the next cycle.
- R6: While a lock is held, the following accesses neither release it nor restart the hold timer: accesses by the owner to other banks, accesses by the owner in the locking direction, and accesses by other masters.
- R7: A lock that is not released is held for exactly `TIMEOUT` cycles. It is then dropped and `irq_o` goes high in the cycle after the drop edge.
- R8: `irq_o` stays set until a cycle with `irq_clr_i` high, and clears after that edge. If a timeout occurs in the same cycle as a clear, the set wins.
- R9: If the releasing access arrives in the final cycle of the hold window, it is a normal release, and `irq_o` is not set.
- R10: After reset, no lock is held, `irq_o` is 0, `lock_master_o` is 0 and `gnt_o` equals `gnt_req_i`.
- R11: While a lock is held, no access can start a new lock or change the recorded owner. This includes the cycle in which the lock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_valid_i | input | 1 | A transaction is on the bus this cycle |
| txn_write_i | input | 1 | 1 = write, 0 = read |
| txn_master_i | input | $clog2(N_MASTERS) | Index of the accessing master |
| txn_bank_i | input | $clog2(N_BANKS) | Bank hit by the access |
| bank_mode_i | input | 2*N_BANKS | Per-bank atomic mode fields |
| gnt_req_i | input | N_MASTERS | Grant vector from the arbiter |
| irq_clr_i | input | 1 | Clears the timeout interrupt flag |
| gnt_o | output | N_MASTERS | Grant vector after lock masking |
| lock_active_o | output | 1 | A lock is held |
| lock_master_o | output | $clog2(N_MASTERS) | Owner of the current lock |
| irq_o | output | 1 | Sticky timeout interrupt |

## Verification
Two pairs of events can fall on the same edge. The first pair is the watchdog expiring and the interrupt clear. The second pair is the watchdog expiring and the owner's releasing access. Directed sequences count exactly `TIMEOUT` held cycles and then drive, in the last held cycle, either the clear input or the completing access. In the first case the interrupt must stay set. In the second case the lock must end with no interrupt. A cycle-level model in the bench judges every cycle of these sequences and of the random traffic, including the grant mask.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_RAW  = 2'b01,
    MODE_WAR  = 2'b10,
    MODE_RSVD = 2'b11
  } bank_mode_e;

  typedef enum logic {
    LK_RAW = 1'b0,
    LK_WAR = 1'b1
  } lock_kind_e;
endpackage

// File: rtl/atomic_lock_decode.sv
module atomic_lock_decode
  import atomic_lock_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_BANKS   = 8,
  localparam int MW = $clog2(N_MASTERS),
  localparam int BW = $clog2(N_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 txn_valid_i,
  input  logic                 txn_write_i,
  input  logic [MW-1:0]        txn_master_i,
  input  logic [BW-1:0]        txn_bank_i,
  input  logic [2*N_BANKS-1:0] bank_mode_i,
  input  logic                 lock_i,
  input  logic [MW-1:0]        owner_i,
  input  logic [BW-1:0]        bank_i,
  input  lock_kind_e           kind_i,
  output logic                 start_o,
  output lock_kind_e           start_kind_o,
  output logic                 release_o
);
  bank_mode_e sel_mode;
  logic       seize_raw, seize_war, pair_done;

  always_comb begin
    sel_mode  = bank_mode_e'(bank_mode_i[{txn_bank_i, 1'b0} +: 2]);
    seize_raw = (sel_mode == MODE_RAW) && txn_write_i;
    seize_war = (sel_mode == MODE_WAR) && !txn_write_i;
    start_o   = txn_valid_i && !lock_i && (seize_raw || seize_war);
    start_kind_o = seize_war ? LK_WAR : LK_RAW;
    // completing access: owner, same bank, opposite direction
    pair_done = (kind_i == LK_RAW) ? !txn_write_i : txn_write_i;
    release_o = txn_valid_i && lock_i && (txn_master_i == owner_i)
                && (txn_bank_i == bank_i) && pair_done;
  end

  a_r3_no_start_nonatomic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_mode_i[{txn_bank_i, 1'b0} +: 2] inside {2'b00, 2'b11}) |-> !start_o);
  a_r11_no_start_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> !start_o);
  a_r6_foreign_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_master_i != owner_i) |-> !release_o);
endmodule

// File: rtl/atomic_lock_timer.sv
module atomic_lock_timer #(
  parameter int TIMEOUT = 256,
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic release_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  always_comb begin
    at_end   = (cnt_q == CW'(TIMEOUT - 1));
    // release in the last window cycle wins over expiry
    expire_o = active_i && at_end && !release_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     cnt_q <= '0;
    else if (active_i && !release_i && !expire_o)    cnt_q <= cnt_q + 1'b1;
    else                                             cnt_q <= '0;
  end

  a_r7_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TIMEOUT - 1));
  a_r6_cnt_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !release_i && !expire_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r7_idle_cnt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/atomic_grant_mask.sv
module atomic_grant_mask #(
  parameter int N_MASTERS = 4,
  localparam int MW = $clog2(N_MASTERS)
) (
  input  logic                 lock_i,
  input  logic [MW-1:0]        owner_i,
  input  logic [N_MASTERS-1:0] req_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  for (genvar g = 0; g < N_MASTERS; g++) begin : g_mst
    logic is_owner;
    assign is_owner = (owner_i == MW'(g));
    assign gnt_o[g] = req_i[g] && (!lock_i || is_owner);
  end
endmodule

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl
  import atomic_lock_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_BANKS   = 8,
  parameter int TIMEOUT   = 256,
  localparam int MW = $clog2(N_MASTERS),
  localparam int BW = $clog2(N_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 txn_valid_i,
  input  logic                 txn_write_i,
  input  logic [MW-1:0]        txn_master_i,
  input  logic [BW-1:0]        txn_bank_i,
  input  logic [2*N_BANKS-1:0] bank_mode_i,
  input  logic [N_MASTERS-1:0] gnt_req_i,
  input  logic                 irq_clr_i,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic                 lock_active_o,
  output logic [MW-1:0]        lock_master_o,
  output logic                 irq_o
);
  logic       lock_q, irq_q;
  logic [MW-1:0] owner_q;
  logic [BW-1:0] bank_q;
  lock_kind_e kind_q, start_kind;
  logic       start, release_evt, expire;

  atomic_lock_decode #(.N_MASTERS(N_MASTERS), .N_BANKS(N_BANKS)) u_decode (
    .clk_i, .rst_ni, .txn_valid_i, .txn_write_i, .txn_master_i, .txn_bank_i,
    .bank_mode_i,
    .lock_i(lock_q), .owner_i(owner_q), .bank_i(bank_q), .kind_i(kind_q),
    .start_o(start), .start_kind_o(start_kind), .release_o(release_evt)
  );

  atomic_lock_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i, .rst_ni, .active_i(lock_q), .release_i(release_evt), .expire_o(expire)
  );

  atomic_grant_mask #(.N_MASTERS(N_MASTERS)) u_mask (
    .lock_i(lock_q), .owner_i(owner_q), .req_i(gnt_req_i), .gnt_o(gnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      bank_q  <= '0;
      kind_q  <= LK_RAW;
    end else if (start) begin
      lock_q  <= 1'b1;
      owner_q <= txn_master_i;
      bank_q  <= txn_bank_i;
      kind_q  <= start_kind;
    end else if (release_evt || expire) begin
      lock_q  <= 1'b0;
    end
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (expire)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign lock_active_o = lock_q;
  assign lock_master_o = owner_q;
  assign irq_o         = irq_q;

  a_r1_start_records_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> lock_q && owner_q == $past(txn_master_i) && bank_q == $past(txn_bank_i));
  a_r2_war_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !txn_write_i) |=> kind_q == LK_WAR);
  a_r4_mask_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> (gnt_o & ~(N_MASTERS'(1) << owner_q)) == '0);
  a_r4_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> gnt_o == gnt_req_i);
  a_r5_release_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_evt |=> !lock_q);
  a_r7_expire_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> irq_q && !lock_q);
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  a_r9_release_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_evt && !irq_q) |=> !irq_q);
  a_r11_owner_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !release_evt && !expire) |=> lock_q && $stable(owner_q) && $stable(bank_q));
endmodule

// File: tb/atomic_lock_ctrl_bench.sv
`timescale 1ns/1ps
module atomic_lock_ctrl_bench;
  localparam int NM = 4, NB = 8, TO = 256, MW = 2, BW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_valid = 0, txn_write = 0, irq_clr = 0;
  logic [MW-1:0] txn_master = '0;
  logic [BW-1:0] txn_bank = '0;
  logic [NM-1:0] gnt_req = '0, gnt_o;
  logic lock_active_o, irq_o;
  logic [MW-1:0] lock_master_o;
  // bank modes: 0:00 1:01 2:10 3:11 4:01 5:10 6:00 7:01
  logic [2*NB-1:0] modes = {2'b01, 2'b00, 2'b10, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};

  always #2.5 clk = ~clk;

  atomic_lock_ctrl #(.N_MASTERS(NM), .N_BANKS(NB), .TIMEOUT(TO)) u_atomic_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .txn_valid_i(txn_valid), .txn_write_i(txn_write),
    .txn_master_i(txn_master), .txn_bank_i(txn_bank), .bank_mode_i(modes),
    .gnt_req_i(gnt_req), .irq_clr_i(irq_clr), .gnt_o(gnt_o),
    .lock_active_o(lock_active_o), .lock_master_o(lock_master_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  string cur = "R10";
  logic m_lock = 0, m_war = 0, m_irq = 0;
  logic [MW-1:0] m_owner = '0;
  logic [BW-1:0] m_bank = '0;
  int m_cnt = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NM-1:0] exp_gnt(logic [NM-1:0] rq);
    return m_lock ? (rq & (NM'(1) << m_owner)) : rq;
  endfunction

  task automatic step(logic v, logic w, logic [MW-1:0] m, logic [BW-1:0] b,
                      logic c, logic [NM-1:0] rq);
    logic rel, ex, st;
    logic [1:0] md;
    @(negedge clk);
    chk({cur, " lock"}, lock_active_o, m_lock);
    chk({cur, " R8 irq"}, irq_o, m_irq);
    if (m_lock) chk({cur, " R1 owner"}, lock_master_o, m_owner);
    txn_valid = v; txn_write = w; txn_master = m; txn_bank = b; irq_clr = c; gnt_req = rq;
    #1;
    chk({cur, " R4 gnt"}, gnt_o, exp_gnt(rq));
    md  = modes[2*b +: 2];
    rel = m_lock && v && m == m_owner && b == m_bank && (m_war ? w : !w);
    ex  = m_lock && !rel && m_cnt == TO - 1;
    st  = !m_lock && v && ((md == 2'b01 && w) || (md == 2'b10 && !w));
    @(posedge clk);
    if (st) begin
      m_lock = 1; m_owner = m; m_bank = b; m_war = (md == 2'b10); m_cnt = 0;
    end else if (rel || ex) begin
      m_lock = 0; m_cnt = 0;
    end else if (m_lock) m_cnt++;
    if (ex) m_irq = 1;
    else if (c) m_irq = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 4'hF);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    int held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    gnt_req = 4'hA;
    #1;
    chk("R10 reset lock", lock_active_o, 0);
    chk("R10 reset irq", irq_o, 0);
    chk("R10 reset owner", lock_master_o, 0);
    chk("R10 reset gnt", gnt_o, 4'hA);
    rst_n = 1;
    idle(2);

    cur = "R3";
    step(1, 1, 1, 0, 0, 4'hF);
    step(1, 1, 1, 3, 0, 4'hF);
    step(1, 0, 1, 1, 0, 4'hF);
    step(1, 1, 1, 2, 0, 4'hF);
    step(1, 0, 1, 3, 0, 4'hF);
    #1 chk("R3 no lock", lock_active_o, 0);

    cur = "R1";
    step(1, 1, 2, 1, 0, 4'hF);
    #1 chk("R1 locked", lock_active_o, 1);
    chk("R1 owner", lock_master_o, 2);
    cur = "R6";
    step(1, 0, 2, 4, 0, 4'hF);
    step(1, 1, 2, 1, 0, 4'hF);
    step(1, 0, 1, 1, 0, 4'hF);
    #1 chk("R6 still locked", lock_active_o, 1);
    cur = "R4";
    step(0, 0, 0, 0, 0, 4'hF);
    step(0, 0, 0, 0, 0, 4'h3);
    cur = "R5";
    step(1, 0, 2, 1, 0, 4'hF);
    #1 chk("R5 raw release", lock_active_o, 0);

    cur = "R2";
    step(1, 0, 0, 2, 0, 4'hF);
    #1 chk("R2 war locked", lock_active_o, 1);
    chk("R2 owner", lock_master_o, 0);
    step(1, 0, 0, 2, 0, 4'hF);
    cur = "R5";
    step(1, 1, 0, 2, 0, 4'hF);
    #1 chk("R5 war release", lock_active_o, 0);

    cur = "R11";
    step(1, 1, 1, 7, 0, 4'hF);
    step(1, 1, 3, 4, 0, 4'hF);
    #1 chk("R11 owner kept", lock_master_o, 1);
    step(1, 0, 1, 7, 0, 4'hF);

    cur = "R7";
    step(1, 1, 3, 4, 0, 4'hF);
    held = 0;
    #1 if (lock_active_o) held++;
    for (int i = 0; i < 400 && lock_active_o; i++) begin
      step(i == 10, 1, 3, 4, 0, 4'hF);
      #1 if (lock_active_o) held++;
    end
    chk("R7 held cycles", held, TO);
    chk("R7 irq set", irq_o, 1);
    cur = "R8";
    idle(3);
    #1 chk("R8 sticky", irq_o, 1);
    step(0, 0, 0, 0, 1, 4'hF);
    #1 chk("R8 cleared", irq_o, 0);

    step(1, 0, 2, 5, 0, 4'hF);
    for (int k = 0; k < TO; k++) step(0, 0, 0, 0, k == TO - 1, 4'hF);
    #1 chk("R8 set wins", irq_o, 1);
    chk("R8 dropped", lock_active_o, 0);
    step(0, 0, 0, 0, 1, 4'hF);

    cur = "R9";
    step(1, 1, 1, 4, 0, 4'hF);
    for (int k = 0; k < TO - 1; k++) step(0, 0, 0, 0, 0, 4'hF);
    step(1, 0, 1, 4, 0, 4'hF);
    #1 chk("R9 no irq", irq_o, 0);
    chk("R9 released", lock_active_o, 0);

    cur = "rand R4";
    for (int i = 0; i < 4000; i++) begin
      logic [MW-1:0] rm;
      rm = m_lock && ($urandom % 2) ? m_owner : MW'($urandom);
      step(($urandom % 3) != 0, $urandom, rm, BW'($urandom),
           ($urandom % 50) == 0, NM'($urandom));
    end
    idle(2);
    report();
  end
endmodule